// File: doc/BRIEF.md
# Receive FIFO Character Time-Out Detector

This block watches a receive FIFO and raises a time-out flag when characters sit in the FIFO unattended. The flag is raised when the FIFO holds at least one character and four full character times go by with no character pushed in and none popped out. The interrupt identification logic uses the flag to report that the software should drain a FIFO that has not reached its trigger level.

The window is counted in bit-rate ticks, not raw clock cycles. One character time is the configured frame length in bits (start bit, five to eight data bits, an optional parity bit, one or two stop bits) times the number of ticks per bit. A push, a pop from either the processor read path or the DMA read path, or the receiver reset control going low clears the flag and restarts the window. The window only runs in FIFO mode and only while the FIFO is non-empty.

Top module: `rx_idle_timeout`

## Requirements
- R1: The window is 4 × F × TICKS_PER_BIT ticks of `bit_tick`. F = 1 + (5 + `cfg_data_len`) + `cfg_parity_en` + (`cfg_two_stop` ? 2 : 1). The encoding of `cfg_data_len` is 0 = 5 data bits, 1 = 6, 2 = 7, 3 = 8.
- R2: With FIFO mode on, `rx_run` high, `fifo_level` non-zero and no push or pop, `rx_timeout` rises at the clock edge that samples the window's last tick. It is still low one tick earlier.
- R3: While `fifo_mode` is 0, `rx_timeout` is low and the tick count is held at zero.
- R4: While `fifo_level` is 0, `rx_timeout` is low and the count is held at zero. After the FIFO becomes non-empty, a full window is needed.
- R5: A push (`rx_push` high at an edge) drops `rx_timeout` at that edge and restarts the window from zero.
- R6: A pop on `rx_pop_cpu` or on `rx_pop_dma` drops `rx_timeout` at that edge and restarts the window. Either path alone is enough.
- R7: `rx_run` low (receiver held in reset) drops `rx_timeout` at the next edge and holds the count at zero.
- R8: Once high, `rx_timeout` stays high through further ticks until a clearing event from R3 to R7 occurs.
- R9: Synchronous reset `rst` forces `rx_timeout` low and the count to zero.
- R10: Clock cycles without `bit_tick` do not advance the count, so `rx_timeout` cannot rise on such a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle bit-rate tick |
| cfg_data_len | input | 2 | Data bits per character, 0..3 = 5..8 |
| cfg_parity_en | input | 1 | Frame carries a parity bit |
| cfg_two_stop | input | 1 | Frame carries two stop bits |
| fifo_level | input | LEVEL_W | Receive FIFO occupancy |
| rx_push | input | 1 | Character written into the receive FIFO |
| rx_pop_cpu | input | 1 | Character read by the processor path |
| rx_pop_dma | input | 1 | Character read by the DMA path |
| fifo_mode | input | 1 | FIFO mode enable |
| rx_run | input | 1 | Receiver reset control, 0 holds receiver in reset |
| rx_timeout | output | 1 | Character time-out flag |

## Verification
All sixteen frame configurations are driven with an unbroken run of ticks. This shows that the flag edge lands on the exact tick that the frame length selects: off by one tick means a wrong frame formula or a compare that is one step late. Runs with some gaps in the ticks tell tick counting apart from cycle counting. Each clearing event is applied alone to a flag that is already high, followed by a full new window, which shows both the clear and the restart from zero. A long random phase mixes sparse pushes, pops, receiver resets, mode changes and level changes. It is checked on every cycle against a model in the bench, which finds events that are dropped or merged wrongly.

// File: rtl/rxto_pkg.sv
package rxto_pkg;

    localparam int CHARS_PER_WINDOW = 4;
    localparam int MIN_DATA_BITS    = 5;
    localparam int MAX_FRAME_BITS   = 12;
    localparam int FBITS_W          = $clog2(MAX_FRAME_BITS + 1);

    typedef struct packed {
        logic [1:0] data_len;
        logic       parity_en;
        logic       two_stop;
    } frame_cfg_t;

    typedef struct packed {
        logic push;
        logic pop;
        logic ctl_reset;
        logic disarmed;
    } restart_src_t;

    typedef enum logic [1:0] {
        TMO_IDLE    = 2'd0,
        TMO_COUNT   = 2'd1,
        TMO_EXPIRED = 2'd2
    } tmo_state_t;

    function automatic logic [FBITS_W-1:0] frame_bits(input frame_cfg_t c);
        logic [FBITS_W-1:0] n;
        n = FBITS_W'(1 + MIN_DATA_BITS + 1);
        n = n + FBITS_W'(c.data_len);
        n = n + FBITS_W'(c.parity_en);
        n = n + FBITS_W'(c.two_stop);
        return n;
    endfunction

    function automatic int window_ticks_max(input int ticks_per_bit);
        return CHARS_PER_WINDOW * MAX_FRAME_BITS * ticks_per_bit;
    endfunction

endpackage

// File: rtl/rxto_window_calc.sv
module rxto_window_calc
    import rxto_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16,
    parameter int LIM_W         = 10
) (
    input  frame_cfg_t         cfg,
    output logic [LIM_W-1:0]   window_ticks
);
    localparam int TICKS_PER_FRAME_BIT = CHARS_PER_WINDOW * TICKS_PER_BIT;

    logic [FBITS_W-1:0] fbits;

    always_comb begin
        fbits        = frame_bits(cfg);
        window_ticks = LIM_W'(fbits) * LIM_W'(TICKS_PER_FRAME_BIT);
    end
endmodule

// File: rtl/rxto_restart_ctl.sv
module rxto_restart_ctl
    import rxto_pkg::*;
#(
    parameter int LEVEL_W   = 5,
    parameter int N_READERS = 2
) (
    input  logic [LEVEL_W-1:0]   fifo_level,
    input  logic                 push,
    input  logic [N_READERS-1:0] pop_vec,
    input  logic                 fifo_mode,
    input  logic                 rx_run,
    output restart_src_t         src,
    output logic                 restart
);
    logic [N_READERS-1:0] pop_seen;

    generate
        for (genvar g = 0; g < N_READERS; g++) begin : g_reader
            if (g == 0) begin : g_first
                assign pop_seen[g] = pop_vec[g];
            end else begin : g_rest
                assign pop_seen[g] = pop_seen[g-1] | pop_vec[g];
            end
        end
    endgenerate

    always_comb begin
        src.push      = push;
        src.pop       = pop_seen[N_READERS-1];
        src.ctl_reset = ~rx_run;
        src.disarmed  = ~fifo_mode | (fifo_level == '0);
        restart       = |src;
    end
endmodule

// File: rtl/rxto_tick_counter.sv
module rxto_tick_counter
    import rxto_pkg::*;
#(
    parameter int LIM_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             bit_tick,
    input  logic [LIM_W-1:0] window_ticks,
    output logic             expired
);
    tmo_state_t       state, state_n;
    logic [LIM_W-1:0] cnt, cnt_n;
    logic [LIM_W:0]   cnt_inc;

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        cnt_inc = {1'b0, cnt} + 1'b1;
        if (restart) begin
            state_n = TMO_IDLE;
            cnt_n   = '0;
        end else begin
            unique case (state)
                TMO_IDLE, TMO_COUNT: begin
                    if (bit_tick) begin
                        cnt_n = cnt_inc[LIM_W-1:0];
                        if (cnt_inc >= {1'b0, window_ticks}) begin
                            state_n = TMO_EXPIRED;
                        end else begin
                            state_n = TMO_COUNT;
                        end
                    end
                end
                TMO_EXPIRED: begin
                    state_n = TMO_EXPIRED;
                end
                default: begin
                    state_n = TMO_IDLE;
                    cnt_n   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TMO_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    assign expired = (state == TMO_EXPIRED);
endmodule

// File: rtl/rx_idle_timeout.sv
module rx_idle_timeout
    import rxto_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16,
    parameter int LEVEL_W       = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bit_tick,
    input  logic [1:0]         cfg_data_len,
    input  logic               cfg_parity_en,
    input  logic               cfg_two_stop,
    input  logic [LEVEL_W-1:0] fifo_level,
    input  logic               rx_push,
    input  logic               rx_pop_cpu,
    input  logic               rx_pop_dma,
    input  logic               fifo_mode,
    input  logic               rx_run,
    output logic               rx_timeout
);
    localparam int LIM_MAX   = window_ticks_max(TICKS_PER_BIT);
    localparam int LIM_W     = $clog2(LIM_MAX + 1);
    localparam int N_READERS = 2;

    frame_cfg_t           cfg;
    logic [LIM_W-1:0]     window_ticks;
    logic [N_READERS-1:0] pop_vec;
    restart_src_t         src;
    logic                 restart;

    assign cfg.data_len  = cfg_data_len;
    assign cfg.parity_en = cfg_parity_en;
    assign cfg.two_stop  = cfg_two_stop;
    assign pop_vec       = {rx_pop_dma, rx_pop_cpu};

    rxto_window_calc #(
        .TICKS_PER_BIT (TICKS_PER_BIT),
        .LIM_W         (LIM_W)
    ) u_win (
        .cfg          (cfg),
        .window_ticks (window_ticks)
    );

    rxto_restart_ctl #(
        .LEVEL_W   (LEVEL_W),
        .N_READERS (N_READERS)
    ) u_rst (
        .fifo_level (fifo_level),
        .push       (rx_push),
        .pop_vec    (pop_vec),
        .fifo_mode  (fifo_mode),
        .rx_run     (rx_run),
        .src        (src),
        .restart    (restart)
    );

    rxto_tick_counter #(
        .LIM_W (LIM_W)
    ) u_cnt (
        .clk          (clk),
        .rst          (rst),
        .restart      (restart),
        .bit_tick     (bit_tick),
        .window_ticks (window_ticks),
        .expired      (rx_timeout)
    );
endmodule

// File: rtl/rxto_checker.sv
module rxto_checker #(
    parameter int LEVEL_W = 5
) (
    input logic               clk,
    input logic               rst,
    input logic               bit_tick,
    input logic [LEVEL_W-1:0] fifo_level,
    input logic               rx_push,
    input logic               rx_pop_cpu,
    input logic               rx_pop_dma,
    input logic               fifo_mode,
    input logic               rx_run,
    input logic               rx_timeout
);
    logic any_clear;
    assign any_clear = rx_push | rx_pop_cpu | rx_pop_dma | ~rx_run |
                       ~fifo_mode | (fifo_level == '0);

    a_r2_rise_on_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_timeout) |-> $past(bit_tick));

    a_r3_quiet_nonfifo: assert property (@(posedge clk) disable iff (rst)
        !fifo_mode |=> !rx_timeout);

    a_r4_quiet_empty: assert property (@(posedge clk) disable iff (rst)
        (fifo_level == '0) |=> !rx_timeout);

    a_r5_push_clears: assert property (@(posedge clk) disable iff (rst)
        rx_push |=> !rx_timeout);

    a_r6_pop_clears: assert property (@(posedge clk) disable iff (rst)
        (rx_pop_cpu || rx_pop_dma) |=> !rx_timeout);

    a_r7_run_low_clears: assert property (@(posedge clk) disable iff (rst)
        !rx_run |=> !rx_timeout);

    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        (rx_timeout && !any_clear) |=> rx_timeout);

    a_r10_no_rise_without_tick: assert property (@(posedge clk) disable iff (rst)
        (!rx_timeout && !bit_tick) |=> !rx_timeout);

    a_r9_reset_low: assert property (@(posedge clk)
        rst |=> !rx_timeout);
endmodule

bind rx_idle_timeout rxto_checker #(.LEVEL_W(LEVEL_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bit_tick   (bit_tick),
    .fifo_level (fifo_level),
    .rx_push    (rx_push),
    .rx_pop_cpu (rx_pop_cpu),
    .rx_pop_dma (rx_pop_dma),
    .fifo_mode  (fifo_mode),
    .rx_run     (rx_run),
    .rx_timeout (rx_timeout)
);

// File: tb/sim_rx_idle_timeout.sv
`timescale 1ns/1ps
module sim_rx_idle_timeout;
    localparam int TPB     = 16;
    localparam int LEVEL_W = 5;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               bit_tick = 1'b0;
    logic [1:0]         cfg_data_len = 2'd3;
    logic               cfg_parity_en = 1'b0;
    logic               cfg_two_stop = 1'b0;
    logic [LEVEL_W-1:0] fifo_level = '0;
    logic               rx_push = 1'b0;
    logic               rx_pop_cpu = 1'b0;
    logic               rx_pop_dma = 1'b0;
    logic               fifo_mode = 1'b1;
    logic               rx_run = 1'b1;
    logic               rx_timeout;

    int  n_chk  = 0;
    int  n_fail = 0;
    int  m_cnt  = 0;
    bit  m_flag = 1'b0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    rx_idle_timeout #(.TICKS_PER_BIT(TPB), .LEVEL_W(LEVEL_W)) u0 (
        .clk(clk), .rst(rst), .bit_tick(bit_tick),
        .cfg_data_len(cfg_data_len), .cfg_parity_en(cfg_parity_en),
        .cfg_two_stop(cfg_two_stop), .fifo_level(fifo_level),
        .rx_push(rx_push), .rx_pop_cpu(rx_pop_cpu), .rx_pop_dma(rx_pop_dma),
        .fifo_mode(fifo_mode), .rx_run(rx_run), .rx_timeout(rx_timeout)
    );

    // R1: window length from the frame configuration
    function automatic int win_ticks(input logic [1:0] dl, input logic p, input logic ts);
        int fb;
        fb = 1 + (5 + int'(dl)) + int'(p) + (ts ? 2 : 1);
        return 4 * fb * TPB;
    endfunction

    function automatic int cur_win();
        return win_ticks(cfg_data_len, cfg_parity_en, cfg_two_stop);
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: rx_timeout=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: inputs held across the edge, model updated, pulses dropped
    task automatic step(input logic tk);
        bit clr;
        bit_tick = tk;
        @(posedge clk);
        #1;
        clr = rx_push | rx_pop_cpu | rx_pop_dma | !rx_run | !fifo_mode | (fifo_level == 0);
        if (rst || clr) begin
            m_cnt  = 0;
            m_flag = 1'b0;
        end else if (!m_flag && tk) begin
            m_cnt++;
            if (m_cnt >= cur_win()) m_flag = 1'b1;
        end
        rx_push    = 1'b0;
        rx_pop_cpu = 1'b0;
        rx_pop_dma = 1'b0;
        bit_tick   = 1'b0;
    endtask

    // counter assumed at zero: run one window, check both sides of the edge
    task automatic run_window(input string tag, input bit gaps);
        int w;
        w = cur_win();
        for (int i = 0; i < w - 1; i++) begin
            step(1'b1);
            if (gaps && (i % 97 == 5)) begin
                for (int k = 0; k < 3; k++) step(1'b0);
            end
        end
        chk({tag, " one tick before window"}, rx_timeout, 1'b0);
        if (gaps) begin
            step(1'b0);
            chk("R10 idle cycle at boundary", rx_timeout, 1'b0);
        end
        step(1'b1);
        chk({tag, " at window edge"}, rx_timeout, 1'b1);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: run hung");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        process::self().srandom(32'h5eed_0a17);
        rst = 1'b1;
        repeat (3) step(1'b1);
        chk("R9 reset state", rx_timeout, 1'b0);
        rst = 1'b0;
        fifo_level = 5'd2;

        // R1/R2: every frame configuration, exact edge
        for (int c = 0; c < 16; c++) begin
            cfg_data_len  = c[1:0];
            cfg_parity_en = c[2];
            cfg_two_stop  = c[3];
            rx_push = 1'b1;
            step(1'b1);
            run_window($sformatf("R1 R2 cfg%0d", c), c[0] ^ c[3]);
        end

        // R8: held through further ticks
        for (int i = 0; i < 200; i++) step(1'b1);
        chk("R8 flag held", rx_timeout, 1'b1);

        cfg_data_len = 2'd0; cfg_parity_en = 1'b0; cfg_two_stop = 1'b0;

        // R6: processor pop clears and restarts
        rx_pop_cpu = 1'b1;
        step(1'b1);
        chk("R6 cpu pop clears", rx_timeout, 1'b0);
        run_window("R6 restart after cpu pop", 1'b0);

        // R6: DMA pop clears and restarts
        rx_pop_dma = 1'b1;
        step(1'b0);
        chk("R6 dma pop clears", rx_timeout, 1'b0);
        run_window("R6 restart after dma pop", 1'b0);

        // R5: push clears and restarts
        rx_push = 1'b1;
        step(1'b1);
        chk("R5 push clears", rx_timeout, 1'b0);
        run_window("R5 restart after push", 1'b0);

        // R7: receiver reset control low
        rx_run = 1'b0;
        step(1'b1);
        chk("R7 run low clears", rx_timeout, 1'b0);
        for (int i = 0; i < cur_win() + 20; i++) step(1'b1);
        chk("R7 held while run low", rx_timeout, 1'b0);
        rx_run = 1'b1;
        run_window("R7 restart after run high", 1'b0);

        // R3: non-FIFO mode
        fifo_mode = 1'b0;
        for (int i = 0; i < 2 * cur_win(); i++) step(1'b1);
        chk("R3 never in non-FIFO mode", rx_timeout, 1'b0);
        fifo_mode = 1'b1;
        run_window("R3 full window after mode on", 1'b0);

        // R4: empty FIFO
        fifo_level = '0;
        step(1'b1);
        chk("R4 empty clears", rx_timeout, 1'b0);
        for (int i = 0; i < 2 * cur_win(); i++) step(1'b1);
        chk("R4 held while empty", rx_timeout, 1'b0);
        fifo_level = 5'd1;
        run_window("R4 full window after non-empty", 1'b0);

        // R10: no ticks, no progress
        rx_push = 1'b1;
        step(1'b0);
        for (int i = 0; i < 2 * cur_win(); i++) step(1'b0);
        chk("R10 no ticks no flag", rx_timeout, 1'b0);

        // R9: reset while expired
        run_window("R2 before reset", 1'b0);
        rst = 1'b1;
        step(1'b1);
        chk("R9 reset clears", rx_timeout, 1'b0);
        rst = 1'b0;

        // random phase checked against the bench model every cycle
        for (int i = 0; i < 24000; i++) begin
            if ($urandom_range(0, 3999) == 0) begin
                cfg_data_len  = 2'($urandom_range(0, 3));
                cfg_parity_en = 1'($urandom_range(0, 1));
                cfg_two_stop  = 1'($urandom_range(0, 1));
            end
            if ($urandom_range(0, 999) == 0)
                fifo_level = ($urandom_range(0, 3) == 0) ? '0 : LEVEL_W'($urandom_range(1, 16));
            if ($urandom_range(0, 1499) == 0) rx_push = 1'b1;
            if ($urandom_range(0, 1999) == 0) rx_pop_cpu = 1'b1;
            if ($urandom_range(0, 1999) == 0) rx_pop_dma = 1'b1;
            rx_run    = ($urandom_range(0, 2999) != 0);
            if ($urandom_range(0, 4999) == 0) fifo_mode = ~fifo_mode;
            if (!fifo_mode && $urandom_range(0, 199) == 0) fifo_mode = 1'b1;
            step(1'($urandom_range(0, 1)));
            chk("R2 R5 R6 R7 R8 random vs model", rx_timeout, m_flag);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule